// File: doc/BRIEF.md
# Banked Host PIO FIFO Window

This block gives a host processor a byte-wide register window of sixteen offsets that decodes into one of two register banks. A configuration location at offset 0xD is visible in both banks; bit 7 of the last value written there picks the bank that every other offset decodes to. The block contains only the bank-select path for bank 0, so all other bank-0 offsets read as zero and ignore writes. Bank 1 holds the programmed-I/O machinery: a 128-byte data FIFO port, a status register, a flag-interrupt-enable register and a signature register that software uses to detect the block.

The FIFO sits between the host and a byte stream on the device side. A direction input chooses its flow. With direction 0 (device to host), the device pushes bytes through a valid/ready input stream and the host pops them by reading the FIFO port. With direction 1 (host to device), the host pushes bytes by writing the FIFO port and the device drains them through a valid/ready output stream. Instead of a byte count, the status register reports a coarse four-bit fill code whose meaning follows the direction. It also carries a sticky error flag for host accesses that underrun or overrun the FIFO, an interrupt flag, and a mode bit that selects programmed I/O.

Two small state machines do the control. The bank machine has the states BANK_LO and BANK_HI: a write to offset 0xD moves it to BANK_HI when data bit 7 is 1 and to BANK_LO when it is 0. The signature machine has the states SIG_EVEN and SIG_ODD, and it alternates between them on every bank-1 read of the signature offset.

Top module: `pio_bank_window`

## Requirements
- R1: After reset the bank machine is in BANK_LO (`bank_sel` = 0). The error flag, interrupt flag, mode bit and enable register are 0, and bank-0 offsets other than 0xD read 0x00.
- R2: A write to offset 0xD selects bank 1 when data bit 7 is 1 (for example 0xB6) and bank 0 when it is 0 (for example 0x04). Offset 0xD reads back the last value written to it in either bank.
- R3: The FIFO holds 128 bytes in first-in first-out order. In bank 1, offset 0x4 is the data port: host reads pop bytes in direction 0 and host writes push bytes in direction 1.
- R4: In direction 0, status bits [4:1] encode the fill level: 1000b for empty, 0000b for 1 to 41 bytes, 0100b for 42 to 83, 0110b for 84 to 127 and 0111b for 128.
- R5: In direction 1, status bits [4:1] encode the free space: 1000b for 128 free, 0000b for 84 to 127 free, 0100b for 42 to 83, 0110b for 1 to 41 and 0111b when full.
- R6: Status bit 7 (the error flag) is set by a host read of the empty FIFO in direction 0 or by a host write to the full FIFO in direction 1. Such an access neither stores nor removes a byte, and the flag stays set until reset.
- R7: Status bit 6 (the interrupt flag) is set by a pulse on `xfer_done` and cleared by a status write with data bit 6 set. `irq` equals the flag ANDed with a nonzero enable register at bank-1 offset 0xB, so writing 0 there masks it.
- R8: Bank-1 offset 0xE reads {01011b, s}. The three-bit field s is 000b on the first read after reset and alternates between 000b and 111b on each read, so two back-to-back reads XOR to 0x07 and every read masked with 0xF8 gives 0x58.
- R9: Status bit 0 reads back the mode bit and drives `pio_mode`. A status write sets it from data bit 0 (1 selects programmed I/O, 0 selects DMA). Status bit 5 reads 0.
- R10: In bank 0, accesses to offsets 0x4, 0x8, 0xB and 0xE have no effect. A FIFO write stores nothing, and a signature read does not advance the signature.
- R11: `dev_in_ready` is high only in direction 0 with the FIFO not full. `dev_out_valid` is high only in direction 1 with the FIFO not empty, and `dev_out_data` presents the oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register window offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the addressed offset (combinational) |
| xfer_dir | input | 1 | 0: device to host, 1: host to device |
| xfer_done | input | 1 | Pulse that raises the interrupt flag |
| dev_in_valid | input | 1 | Device byte available |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | FIFO accepts a device byte |
| dev_out_valid | output | 1 | FIFO byte available to the device |
| dev_out_data | output | 8 | Oldest FIFO byte |
| dev_out_ready | input | 1 | Device takes the byte |
| irq | output | 1 | Masked interrupt request |
| pio_mode | output | 1 | Programmed-I/O mode bit |
| bank_sel | output | 1 | Current bank (1 = BANK_HI) |

## Verification
The FIFO is exercised in both directions. Direction 0 fills it byte by byte from the device stream and empties it by host reads. Direction 1 fills it by host writes while the device is stalled and then drains it at full rate. The status code is sampled on both sides of every threshold (1/41/42/83/84/127/128 stored, and the matching free counts), which separates an off-by-one in the boundaries and a swapped direction mapping from a correct coder. One extra access past full and one past empty show whether the error flag is raised and whether the data stream is left untouched. Accesses made in bank 0 before the bank switch show whether the window decode really gates the FIFO and signature side effects.

// File: rtl/pio_win_pkg.sv
package pio_win_pkg;

    localparam logic [3:0] OFS_FIFO = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;
    localparam logic [3:0] OFS_FLAG = 4'hB;
    localparam logic [3:0] OFS_CFG  = 4'hD;
    localparam logic [3:0] OFS_SIG  = 4'hE;

    localparam logic [3:0] LVL_EDGE  = 4'b1000;
    localparam logic [3:0] LVL_BAND0 = 4'b0000;
    localparam logic [3:0] LVL_BAND1 = 4'b0100;
    localparam logic [3:0] LVL_BAND2 = 4'b0110;
    localparam logic [3:0] LVL_LIMIT = 4'b0111;

    localparam logic [4:0] SIG_PREFIX = 5'b01011;

    typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;
    typedef enum logic {SIG_EVEN = 1'b0, SIG_ODD = 1'b1} sig_e;

endpackage

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign full  = (count == DEPTH_C);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pio_level_coder.sv
module pio_level_coder
    import pio_win_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          dir,
    input  logic [CW-1:0] count,
    output logic [3:0]    code
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] LO_MARK = CW'((DEPTH * 21) / 64);
    localparam logic [CW-1:0] HI_MARK = CW'((DEPTH * 21) / 32);

    logic [CW-1:0] free_cnt;
    assign free_cnt = DEPTH_C - count;

    always_comb begin
        if (!dir) begin
            if (count == '0)            code = LVL_EDGE;
            else if (count == DEPTH_C)  code = LVL_LIMIT;
            else if (count >= HI_MARK)  code = LVL_BAND2;
            else if (count >= LO_MARK)  code = LVL_BAND1;
            else                        code = LVL_BAND0;
        end else begin
            if (free_cnt == DEPTH_C)     code = LVL_EDGE;
            else if (free_cnt == '0)     code = LVL_LIMIT;
            else if (free_cnt >= HI_MARK) code = LVL_BAND0;
            else if (free_cnt >= LO_MARK) code = LVL_BAND1;
            else                         code = LVL_BAND2;
        end
    end

endmodule

// File: rtl/pio_signature.sv
module pio_signature
    import pio_win_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [7:0] value
);
    sig_e state_q;
    sig_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SIG_EVEN: if (step) state_d = SIG_ODD;
            SIG_ODD:  if (step) state_d = SIG_EVEN;
            default:  state_d = SIG_EVEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SIG_EVEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SIG_ODD: value = {SIG_PREFIX, 3'b111};
            default: value = {SIG_PREFIX, 3'b000};
        endcase
    end

endmodule

// File: rtl/pio_bank_window.sv
module pio_bank_window
    import pio_win_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       xfer_dir,
    input  logic       xfer_done,
    input  logic       dev_in_valid,
    input  logic [7:0] dev_in_data,
    output logic       dev_in_ready,
    output logic       dev_out_valid,
    output logic [7:0] dev_out_data,
    input  logic       dev_out_ready,
    output logic       irq,
    output logic       pio_mode,
    output logic       bank_sel
);
    bank_e         bank_q;
    bank_e         bank_d;
    logic [7:0]    cfg_q;
    logic [7:0]    flag_en_q;
    logic          err_q;
    logic          int_q;
    logic          pio_q;

    logic [7:0]    fifo_head;
    logic [CW-1:0] fill_count;
    logic          fifo_full;
    logic          fifo_empty;
    logic [3:0]    level_code;
    logic [7:0]    sig_value;

    logic hi_wr;
    logic hi_rd;
    logic host_push;
    logic host_pop;
    logic host_overrun;
    logic host_underrun;
    logic fifo_push;
    logic fifo_pop;
    logic sig_step;

    // Bank-1 access qualifiers
    assign hi_wr = host_wr && (bank_q == BANK_HI);
    assign hi_rd = host_rd && (bank_q == BANK_HI);

    assign host_push     = hi_wr && (host_addr == OFS_FIFO) && xfer_dir && !fifo_full;
    assign host_overrun  = hi_wr && (host_addr == OFS_FIFO) && xfer_dir && fifo_full;
    assign host_pop      = hi_rd && (host_addr == OFS_FIFO) && !xfer_dir && !fifo_empty;
    assign host_underrun = hi_rd && (host_addr == OFS_FIFO) && !xfer_dir && fifo_empty;
    assign sig_step      = hi_rd && (host_addr == OFS_SIG);

    assign dev_in_ready  = !xfer_dir && !fifo_full;
    assign dev_out_valid = xfer_dir && !fifo_empty;
    assign dev_out_data  = fifo_head;

    assign fifo_push = host_push || (dev_in_valid && dev_in_ready);
    assign fifo_pop  = host_pop  || (dev_out_valid && dev_out_ready);

    pio_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (xfer_dir ? host_wdata : dev_in_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fill_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    pio_level_coder #(.DEPTH(DEPTH)) u_level (
        .dir   (xfer_dir),
        .count (fill_count),
        .code  (level_code)
    );

    pio_signature u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sig_step),
        .value (sig_value)
    );

    // Bank state machine: next state
    always_comb begin
        bank_d = bank_q;
        unique case (bank_q)
            BANK_LO: if (host_wr && host_addr == OFS_CFG &&  host_wdata[7]) bank_d = BANK_HI;
            BANK_HI: if (host_wr && host_addr == OFS_CFG && !host_wdata[7]) bank_d = BANK_LO;
            default: bank_d = BANK_LO;
        endcase
    end

    // Bank state register
    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= BANK_LO;
        else        bank_q <= bank_d;
    end

    // Register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            flag_en_q <= '0;
            err_q     <= 1'b0;
            int_q     <= 1'b0;
            pio_q     <= 1'b0;
        end else begin
            if (host_wr && host_addr == OFS_CFG) cfg_q <= host_wdata;
            if (hi_wr && host_addr == OFS_FLAG)  flag_en_q <= host_wdata;
            if (hi_wr && host_addr == OFS_STAT)  pio_q <= host_wdata[0];
            if (host_overrun || host_underrun)   err_q <= 1'b1;
            if (xfer_done)
                int_q <= 1'b1;
            else if (hi_wr && host_addr == OFS_STAT && host_wdata[6])
                int_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        host_rdata = '0;
        unique case (bank_q)
            BANK_HI: begin
                unique case (host_addr)
                    OFS_FIFO: host_rdata = (!xfer_dir && !fifo_empty) ? fifo_head : 8'h00;
                    OFS_STAT: host_rdata = {err_q, int_q, 1'b0, level_code, pio_q};
                    OFS_FLAG: host_rdata = flag_en_q;
                    OFS_CFG:  host_rdata = cfg_q;
                    OFS_SIG:  host_rdata = sig_value;
                    default:  host_rdata = 8'h00;
                endcase
            end
            default: host_rdata = (host_addr == OFS_CFG) ? cfg_q : 8'h00;
        endcase
    end

    assign irq      = int_q && (flag_en_q != 8'h00);
    assign pio_mode = pio_q;
    assign bank_sel = (bank_q == BANK_HI);

endmodule

// File: rtl/pio_bank_window_chk.sv
module pio_bank_window_chk #(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    host_addr,
    input logic          host_wr,
    input logic          host_rd,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic          xfer_dir,
    input logic          bank_sel,
    input logic          dev_in_ready,
    input logic          dev_out_valid,
    input logic          irq,
    input logic          err_flag,
    input logic          int_flag,
    input logic [CW-1:0] fill_count,
    input logic [3:0]    level_code
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    p_bank_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'hD) |=> (bank_sel == $past(host_wdata[7])));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= DEPTH_C);

    p_empty_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_dir && fill_count == '0) |-> (level_code == 4'b1000));

    p_full_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_dir && fill_count == DEPTH_C) |-> (level_code == 4'b0111));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_flag);

    p_sig_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel && host_rd && host_addr == 4'hE) |-> (host_rdata[7:3] == 5'b01011));

    p_in_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_ready |-> (!xfer_dir && fill_count < DEPTH_C));

    p_out_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> (xfer_dir && fill_count != '0));

endmodule

bind pio_bank_window pio_bank_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .xfer_dir      (xfer_dir),
    .bank_sel      (bank_sel),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .irq           (irq),
    .err_flag      (err_q),
    .int_flag      (int_q),
    .fill_count    (fill_count),
    .level_code    (level_code)
);

// File: tb/pio_bank_window_bench.sv
`timescale 1ns/1ps
module pio_bank_window_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       xfer_dir = 1'b0;
    logic       xfer_done = 1'b0;
    logic       dev_in_valid = 1'b0;
    logic [7:0] dev_in_data = '0;
    logic       dev_in_ready;
    logic       dev_out_valid;
    logic [7:0] dev_out_data;
    logic       dev_out_ready = 1'b0;
    logic       irq;
    logic       pio_mode;
    logic       bank_sel;

    int checks = 0;
    int fails  = 0;
    int out_seen = 0;
    bit done = 1'b0;

    logic [7:0] in_q[$];
    logic [7:0] out_q[$];

    always #4 clk = ~clk;

    pio_bank_window u_pio_bank_window (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_dir(xfer_dir), .xfer_done(xfer_done), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .irq(irq), .pio_mode(pio_mode),
        .bank_sel(bank_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        in_q.delete();
        out_q.delete();
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #3;
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic dev_push(input logic [7:0] b);
        @(negedge clk);
        dev_in_valid = 1'b1; dev_in_data = b;
        #3;
        while (!dev_in_ready) begin
            @(negedge clk);
            #3;
        end
        in_q.push_back(b);
        @(negedge clk);
        dev_in_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    // Monitor: device-side output stream against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && dev_out_valid && dev_out_ready) begin
                if (out_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected device byte", dev_out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = out_q.pop_front();
                    chk(dev_out_data == e, "R3 device byte order", dev_out_data, e);
                end
                out_seen++;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] s0;
        logic [7:0] s1;

        // ---------------- R1 reset state ----------------
        do_reset();
        #3;
        chk(bank_sel == 1'b0, "R1 bank after reset", bank_sel, 0);
        chk(irq == 1'b0 && pio_mode == 1'b0, "R1 irq/pio after reset", {irq, pio_mode}, 0);
        hread(4'h8, d);
        chk(d == 8'h00, "R1 bank0 offset 8 reads zero", d, 8'h00);

        // ---------------- R10 bank0 side effects ----------------
        xfer_dir = 1'b1;
        hwrite(4'h4, 8'hAA);
        hread(4'hE, d);
        hread(4'hE, d);
        chk(d == 8'h00, "R10 bank0 signature offset reads zero", d, 0);
        @(negedge clk); #3;
        chk(dev_out_valid == 1'b0, "R10 bank0 FIFO write stored nothing", dev_out_valid, 0);

        // ---------------- R2 bank switch ----------------
        hwrite(4'hD, 8'hB6);
        #1;
        chk(bank_sel == 1'b1, "R2 0xB6 selects bank1", bank_sel, 1);
        hread(4'hD, d);
        chk(d == 8'hB6, "R2 config readback", d, 8'hB6);

        // ---------------- R8 signature ----------------
        hread(4'hE, s0);
        hread(4'hE, s1);
        chk(s0 == 8'h58, "R8 first signature read (R10 no earlier step)", s0, 8'h58);
        chk((s0 ^ s1) == 8'h07, "R8 back-to-back XOR", s0 ^ s1, 7);
        chk((s1 & 8'hF8) == 8'h58, "R8 masked value", s1 & 8'hF8, 8'h58);

        // ---------------- R5 direction 1 free-space codes ----------------
        hread(4'h8, d);
        chk(d == 8'h10, "R5 all free", d, 8'h10);
        for (int n = 1; n <= 128; n++) begin
            logic [7:0] b;
            b = 8'(n * 5 + 3);
            hwrite(4'h4, b);
            out_q.push_back(b);
            if (n == 1 || n == 44 || n == 45 || n == 86 || n == 87 || n == 127 || n == 128) begin
                logic [7:0] e;
                hread(4'h8, d);
                if (n <= 44)       e = 8'h00;
                else if (n <= 86)  e = 8'h08;
                else if (n <= 127) e = 8'h0C;
                else               e = 8'h0E;
                chk(d == e, $sformatf("R5 code after %0d writes", n), d, e);
            end
        end
        // overrun
        hwrite(4'h4, 8'hEE);
        hread(4'h8, d);
        chk(d == 8'h8E, "R6 overrun sets error", d, 8'h8E);
        @(negedge clk); #3;
        chk(dev_out_valid == 1'b1 && dev_out_data == 8'd8, "R11 oldest byte presented", dev_out_data, 8);
        @(negedge clk);
        dev_out_ready = 1'b1;
        repeat (140) @(negedge clk);
        #3;
        chk(out_seen == 128, "R3 device received 128 bytes (R6 overrun byte dropped)", out_seen, 128);
        chk(dev_out_valid == 1'b0, "R11 valid low when empty", dev_out_valid, 0);
        dev_out_ready = 1'b0;

        // ---------------- R4 direction 0 fill codes ----------------
        do_reset();
        xfer_dir = 1'b0;
        hwrite(4'hD, 8'h80);
        hwrite(4'h8, 8'h01);
        #1;
        chk(pio_mode == 1'b1, "R9 pio mode output", pio_mode, 1);
        hread(4'h8, d);
        chk(d == 8'h11, "R4 empty with R9 mode bit", d, 8'h11);
        for (int n = 1; n <= 128; n++) begin
            dev_push(8'(n * 7 + 1));
            if (n == 1 || n == 41 || n == 42 || n == 83 || n == 84 || n == 127 || n == 128) begin
                logic [7:0] e;
                hread(4'h8, d);
                if (n <= 41)       e = 8'h01;
                else if (n <= 83)  e = 8'h09;
                else if (n <= 127) e = 8'h0D;
                else               e = 8'h0F;
                chk(d == e, $sformatf("R4 code after %0d bytes", n), d, e);
            end
        end
        @(negedge clk); #3;
        chk(dev_in_ready == 1'b0, "R11 ready low when full", dev_in_ready, 0);
        for (int n = 0; n < 128; n++) begin
            logic [7:0] e;
            hread(4'h4, d);
            e = in_q.pop_front();
            chk(d == e, "R3 host read order", d, e);
        end
        hread(4'h8, d);
        chk(d == 8'h11, "R4 empty after drain, no error", d, 8'h11);
        hread(4'h4, d);
        hread(4'h8, d);
        chk(d == 8'h91, "R6 underrun sets error", d, 8'h91);

        // ---------------- R7 interrupt ----------------
        pulse_done();
        hread(4'h8, d);
        chk(d == 8'hD1, "R7 flag set by xfer_done", d, 8'hD1);
        #1;
        chk(irq == 1'b0, "R7 irq masked by zero enable", irq, 0);
        hwrite(4'hB, 8'h01);
        #1;
        chk(irq == 1'b1, "R7 irq enabled", irq, 1);
        hwrite(4'hB, 8'h00);
        #1;
        chk(irq == 1'b0, "R7 zero enable disables irq", irq, 0);
        hwrite(4'h8, 8'h41);
        hread(4'h8, d);
        chk(d == 8'h91, "R7 clear flag, R6 error still set", d, 8'h91);
        hwrite(4'h8, 8'h00);
        #1;
        chk(pio_mode == 1'b0, "R9 DMA mode selected", pio_mode, 0);

        // ---------------- R2 back to bank0, R1 reset clears error ----------------
        hwrite(4'hD, 8'h04);
        #1;
        chk(bank_sel == 1'b0, "R2 0x04 selects bank0", bank_sel, 0);
        hread(4'hD, d);
        chk(d == 8'h04, "R2 config readback in bank0", d, 8'h04);
        do_reset();
        hwrite(4'hD, 8'hB6);
        hread(4'h8, d);
        chk(d == 8'h10, "R1 reset clears error and mode", d, 8'h10);

        finish_run();
    end

endmodule